// File: doc/BRIEF.md
# Ethernet destination address filter

This block sits at the head of a receive path and decides, from the destination address alone, whether an incoming frame should be kept. The address bytes arrive one per clock on a byte stream, the first byte tagged by a frame-start flag. After the last address byte the block raises a one-cycle decision strobe together with an accept bit. Storing the frame is left to the logic downstream.

Four filters are combined in a fixed priority. A promiscuous mode keeps everything. An all-ones address is broadcast and depends on its own enable. Any other address with the group bit set is multicast: it is gated by a multicast enable and by one bit of a 64-bit hash mask, selected by a bit-serial CRC taken over the address. The remaining addresses are kept only on an exact match with the station address.

The receive configuration is captured when the frame starts, so software may rewrite it at any time without affecting a frame whose address is already on its way in.

Top module: `rxf_dest_filter`

## Requirements
- R1: When bit 4 of `rx_cfg` (promiscuous) is set at frame start, the decision is accept for any address.
- R2: Without promiscuous mode, an address of six 0xFF bytes is accepted exactly when bit 2 of `rx_cfg` is set; it is never judged as multicast.
- R3: Without promiscuous mode, any other address whose first byte has bit 0 set is accepted only when bit 3 of `rx_cfg` is set and `mcast_mask[h]` is 1, where mask byte k occupies bits 8k+7..8k, so h selects byte h/8, bit h%8.
- R4: The index h is bits 31..26 of a CRC that starts at all ones and takes each address byte in arrival order, bit 0 first; per bit, feedback = CRC bit 31 XOR data bit, the CRC shifts left one place, and on feedback 1 it is XORed with 0x04C11DB6 and bit 0 is then set.
- R5: Without promiscuous mode, an address whose first byte has bit 0 clear is accepted only when all six bytes equal `station_addr`, whose byte k (k = 0 is the first on the wire) sits at bits 8k+7..8k.
- R6: `decide_valid` is high for exactly the one cycle after the clock edge that takes the sixth address byte; idle cycles between bytes are allowed; `decide_accept` is 0 whenever `decide_valid` is 0.
- R7: A byte with `byte_first` set starts a new address, discarding the CRC and match state of any unfinished one.
- R8: `rx_cfg` is sampled with the first byte; changes during the rest of the address do not alter that frame's decision.
- R9: After reset both outputs are 0; bytes arriving before any frame start, and bytes after the sixth, produce no decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_valid | input | 1 | An address byte is present this cycle |
| byte_first | input | 1 | The present byte is the first of a frame |
| byte_data | input | 8 | Address byte |
| rx_cfg | input | 8 | Receive configuration (bits 2, 3, 4 used) |
| mcast_mask | input | 64 | Multicast hash mask |
| station_addr | input | 48 | Own unicast address |
| decide_valid | output | 1 | Decision strobe |
| decide_accept | output | 1 | Accept the frame (valid with the strobe) |

## Verification
The bench builds the block with its default parameters: six address bytes, a six-bit hash index and a 64-bit mask, which puts every mask bit within reach of a directed hash test. Expected decisions come from a separate model of the priority rules and the CRC, so a mask holding only the predicted bit must accept and a mask lacking only that bit must reject. Directed cases cover the configuration snapshot, restarts in mid-address, idle gaps between bytes and stray bytes around a frame.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int CRC_W = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C1_1DB6;

  // Positions in the receive configuration byte
  localparam int CFG_BCAST_BIT   = 2;
  localparam int CFG_MCAST_BIT   = 3;
  localparam int CFG_PROMISC_BIT = 4;

  // One byte through the serial hash, bit 0 first
  function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c_in,
                                                input logic [7:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = c_in;
    for (int b = 0; b < 8; b++) begin
      fb = c[CRC_W-1] ^ d[b];
      c  = c << 1;
      if (fb) c = (c ^ CRC_POLY) | {{(CRC_W-1){1'b0}}, 1'b1};
    end
    return c;
  endfunction

endpackage

// File: rtl/rxf_seq.sv
module rxf_seq #(
  parameter int ADDR_BYTES = 6,
  parameter int CFG_W      = 8,
  localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_valid,
  input  logic             byte_first,
  input  logic [CFG_W-1:0] cfg_in,
  output logic             take,
  output logic [CNT_W-1:0] idx,
  output logic [CFG_W-1:0] cfg_eff
);

  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CFG_W-1:0] cfg_q, cfg_n;

  // A byte is taken on a frame start, or while an address is still open
  always_comb begin
    take    = byte_valid && (byte_first ||
              (cnt_q != '0 && cnt_q < CNT_W'(ADDR_BYTES)));
    idx     = byte_first ? '0 : cnt_q;
    cnt_n   = take ? idx + CNT_W'(1) : cnt_q;
    cfg_n   = (byte_valid && byte_first) ? cfg_in : cfg_q;
    cfg_eff = (byte_valid && byte_first) ? cfg_in : cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cfg_q <= '0;
    end else begin
      cnt_q <= cnt_n;
      cfg_q <= cfg_n;
    end
  end

  // R9: the byte counter never runs past the address length
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(ADDR_BYTES));

  // R8: the configuration copy moves only on a frame start
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(byte_valid && byte_first) |=> $stable(cfg_q));

endmodule

// File: rtl/rxf_hash.sv
module rxf_hash
  import rxf_pkg::*;
#(
  parameter int HASH_BITS = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 take,
  input  logic                 first,
  input  logic [7:0]           data,
  output logic [HASH_BITS-1:0] hash_idx
);

  logic [CRC_W-1:0] crc_q, crc_base, crc_n;

  always_comb begin
    crc_base = first ? '1 : crc_q;
    crc_n    = crc_byte(crc_base, data);
    hash_idx = crc_n[CRC_W-1 -: HASH_BITS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc_q <= '1;
    end else if (take) begin
      crc_q <= crc_n;
    end
  end

  // R7: the running hash only moves when an address byte is taken
  p_crc_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(crc_q));

endmodule

// File: rtl/rxf_cmp.sv
module rxf_cmp #(
  parameter int ADDR_BYTES = 6,
  localparam int CNT_W     = $clog2(ADDR_BYTES + 1),
  localparam int ADDR_W    = 8 * ADDR_BYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              first,
  input  logic [CNT_W-1:0]  idx,
  input  logic [7:0]        data,
  input  logic [ADDR_W-1:0] station,
  output logic              ones_n,
  output logic              stn_n,
  output logic              grp_n
);

  logic ones_q, stn_q, grp_q;
  logic [7:0] stn_byte;

  always_comb begin
    stn_byte = station[8*idx +: 8];
    ones_n   = (first ? 1'b1 : ones_q) && (data == 8'hFF);
    stn_n    = (first ? 1'b1 : stn_q) && (data == stn_byte);
    grp_n    = first ? data[0] : grp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ones_q <= 1'b0;
      stn_q  <= 1'b0;
      grp_q  <= 1'b0;
    end else if (take) begin
      ones_q <= ones_n;
      stn_q  <= stn_n;
      grp_q  <= grp_n;
    end
  end

  // R2: an address that is all ones always carries the group bit
  p_ones_grp_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ones_q |-> grp_q);

endmodule

// File: rtl/rxf_dest_filter.sv
module rxf_dest_filter
  import rxf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_BITS  = 6,
  localparam int MASK_W    = 1 << HASH_BITS,
  localparam int ADDR_W    = 8 * ADDR_BYTES,
  localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  logic              byte_first,
  input  logic [7:0]        byte_data,
  input  logic [7:0]        rx_cfg,
  input  logic [MASK_W-1:0] mcast_mask,
  input  logic [ADDR_W-1:0] station_addr,
  output logic              decide_valid,
  output logic              decide_accept
);

  logic                 take;
  logic [CNT_W-1:0]     idx;
  logic [7:0]           cfg_eff;
  logic [HASH_BITS-1:0] hash_idx;
  logic                 ones_n, stn_n, grp_n;
  logic                 last, acc;
  logic                 valid_q, acc_q;
  logic                 cfg_unused;

  assign cfg_unused = ^{cfg_eff[7:5], cfg_eff[1:0]};

  rxf_seq #(.ADDR_BYTES(ADDR_BYTES), .CFG_W(8)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .byte_first (byte_first),
    .cfg_in     (rx_cfg),
    .take       (take),
    .idx        (idx),
    .cfg_eff    (cfg_eff)
  );

  rxf_hash #(.HASH_BITS(HASH_BITS)) u_hash (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .first    (byte_first),
    .data     (byte_data),
    .hash_idx (hash_idx)
  );

  rxf_cmp #(.ADDR_BYTES(ADDR_BYTES)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .first   (byte_first),
    .idx     (idx),
    .data    (byte_data),
    .station (station_addr),
    .ones_n  (ones_n),
    .stn_n   (stn_n),
    .grp_n   (grp_n)
  );

  // Priority: promiscuous, broadcast, multicast hash, exact unicast
  always_comb begin
    last = take && (idx == CNT_W'(ADDR_BYTES - 1));
    if (cfg_eff[CFG_PROMISC_BIT])  acc = 1'b1;
    else if (ones_n)               acc = cfg_eff[CFG_BCAST_BIT];
    else if (grp_n)                acc = cfg_eff[CFG_MCAST_BIT] && mcast_mask[hash_idx];
    else                           acc = stn_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      acc_q   <= 1'b0;
    end else begin
      valid_q <= last;
      acc_q   <= last && acc;
    end
  end

  assign decide_valid  = valid_q;
  assign decide_accept = acc_q;

  // R6: accept is never raised without the strobe
  p_acc_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !decide_valid |-> !decide_accept);

  // R1: a frame opened in promiscuous mode is accepted
  p_promisc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (last && cfg_eff[CFG_PROMISC_BIT]) |=> decide_accept);

  generate
    if (ADDR_BYTES > 1) begin : g_pulse
      // R6: a decision is a single-cycle pulse
      p_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        decide_valid |=> !decide_valid);
    end
  endgenerate

endmodule

// File: tb/rxf_dest_filter_bench.sv
module rxf_dest_filter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byte_valid = 1'b0;
  logic        byte_first = 1'b0;
  logic [7:0]  byte_data = 8'h00;
  logic [7:0]  rx_cfg = 8'h00;
  logic [63:0] mcast_mask = 64'h0;
  logic [47:0] station_addr = 48'h0;
  logic        decide_valid, decide_accept;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  rxf_dest_filter u_rxf_dest_filter (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_first(byte_first),
    .byte_data(byte_data), .rx_cfg(rx_cfg), .mcast_mask(mcast_mask),
    .station_addr(station_addr), .decide_valid(decide_valid),
    .decide_accept(decide_accept)
  );

  localparam logic [47:0] STN  = 48'h5544_3322_1102;
  localparam logic [63:0] MASK = 64'hA5A5_5A5A_0F0F_F0F0;

  // {rx_cfg, address}; address byte 0 (first on the wire) in bits 7:0
  localparam int NV = 10;
  localparam logic [55:0] VEC [NV] = '{
    {8'h00, 48'h5544_3322_1102},  // R5 exact match
    {8'h00, 48'h5644_3322_1102},  // R5 last byte differs
    {8'h0C, 48'h5544_3322_1104},  // R5 first byte differs
    {8'h04, 48'hFFFF_FFFF_FFFF},  // R2 broadcast enabled
    {8'h08, 48'hFFFF_FFFF_FFFF},  // R2 broadcast disabled, mcast on
    {8'h08, 48'h0100_005E_0001},  // R3 multicast
    {8'h00, 48'h0100_005E_0001},  // R3 multicast disabled
    {8'h10, 48'h1234_5678_9ABC},  // R1 promiscuous
    {8'h0C, 48'h0000_0000_0033},  // R3 another multicast
    {8'h10, 48'hFFFF_FFFF_FFFF}   // R1 promiscuous broadcast
  };

  function automatic logic [5:0] m_hash(input logic [47:0] a);
    logic [31:0] c;
    logic fb;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < 6; k++) begin
      for (int j = 0; j < 8; j++) begin
        fb = c[31] ^ a[8*k + j];
        c = {c[30:0], 1'b0};
        if (fb) c = (c ^ 32'h04C1_1DB6) | 32'h1;
      end
    end
    return c[31:26];
  endfunction

  function automatic logic m_accept(input logic [47:0] a, input logic [7:0] cf,
                                    input logic [63:0] mk, input logic [47:0] st);
    logic [5:0] h;
    h = m_hash(a);
    if (cf[4]) return 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) return cf[2];
    if (a[0]) return cf[3] && mk[{h[5:3], 3'b000} + h[2:0]];
    return a == st;
  endfunction

  task automatic check(input logic cond, input string tag, input int act, input int exp);
    total++;
    if (!cond) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put_byte(input logic [7:0] b, input logic f);
    byte_valid = 1'b1;
    byte_first = f;
    byte_data  = b;
    @(negedge clk);
    byte_valid = 1'b0;
    byte_first = 1'b0;
  endtask

  // Sends a six-byte address; cfg c0 at the first byte, c1 afterwards.
  // Returns the strobe/accept seen right after the sixth byte and whether
  // the strobe rose too early.
  task automatic run_frame(input logic [47:0] a, input logic [7:0] c0,
                           input logic [7:0] c1, input int gap,
                           output logic v, output logic acc, output logic early);
    early = 1'b0;
    rx_cfg = c0;
    for (int k = 0; k < 6; k++) begin
      put_byte(a[8*k +: 8], k == 0);
      if (k == 0) rx_cfg = c1;
      if (k < 5) begin
        if (decide_valid) early = 1'b1;
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          if (decide_valid) early = 1'b1;
        end
      end
    end
    v = decide_valid;
    acc = decide_accept;
  endtask

  task automatic frame_check(input logic [47:0] a, input logic [7:0] c0,
                             input logic [7:0] c1, input int gap,
                             input logic exp, input string tag);
    logic v, acc, early;
    run_frame(a, c0, c1, gap, v, acc, early);
    check(v && !early, {tag, " strobe"}, {early, v}, 1);
    check(acc == exp, {tag, " accept"}, acc, exp);
    @(negedge clk);
    check(!decide_valid && !decide_accept, {tag, " pulse end R6"}, decide_valid, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [5:0] h;
    logic v, acc, early;
    station_addr = STN;
    mcast_mask = MASK;
    repeat (3) @(negedge clk);
    check(!decide_valid && !decide_accept, "reset outputs R9", decide_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: bytes before any frame start are ignored
    for (int k = 0; k < 8; k++) begin
      put_byte(8'hFF, 1'b0);
      check(!decide_valid, "no frame start R9", decide_valid, 0);
    end

    // Table walk: R1 R2 R3 R5
    for (int i = 0; i < NV; i++) begin
      frame_check(VEC[i][47:0], VEC[i][55:48], VEC[i][55:48], 0,
                  m_accept(VEC[i][47:0], VEC[i][55:48], MASK, STN),
                  $sformatf("table %0d (R1 R2 R3 R5)", i));
    end

    // R4: only the predicted mask bit set -> accept; only it clear -> reject
    h = m_hash(48'h0100_005E_0001);
    mcast_mask = 64'h1 << h;
    frame_check(48'h0100_005E_0001, 8'h08, 8'h08, 0, 1'b1, "hash bit alone R4");
    mcast_mask = ~(64'h1 << h);
    frame_check(48'h0100_005E_0001, 8'h08, 8'h08, 0, 1'b0, "hash bit clear R4");
    h = m_hash(48'hCAFE_0BAD_F00D);
    mcast_mask = 64'h1 << h;
    frame_check(48'hCAFE_0BAD_F00D, 8'h08, 8'h08, 1, 1'b1, "hash second addr R4");

    // R8: configuration changed after the first byte has no effect
    mcast_mask = MASK;
    frame_check(48'h1234_5678_9ABC, 8'h10, 8'h00, 0, 1'b1, "cfg snapshot keep R8");
    frame_check(48'h1234_5678_9ABC, 8'h00, 8'h10, 0, 1'b0, "cfg snapshot late R8");

    // R6: idle gaps between bytes
    frame_check(STN, 8'h00, 8'h00, 3, 1'b1, "gapped unicast R6");

    // R7: restart in mid-address clears hash and match state
    rx_cfg = 8'h04;
    for (int k = 0; k < 3; k++) put_byte(8'hFF, k == 0);
    frame_check(STN, 8'h00, 8'h00, 0, 1'b1, "restart to unicast R7");
    h = m_hash(48'h0100_005E_0001);
    mcast_mask = 64'h1 << h;
    rx_cfg = 8'h08;
    put_byte(8'h33, 1'b1);
    put_byte(8'h77, 1'b0);
    put_byte(8'h12, 1'b0);
    put_byte(8'h9A, 1'b0);
    frame_check(48'h0100_005E_0001, 8'h08, 8'h08, 0, 1'b1, "restart multicast R7");
    rx_cfg = 8'h00;
    put_byte(8'h02, 1'b1);
    put_byte(8'h11, 1'b0);
    frame_check(48'h5544_3322_1108, 8'h00, 8'h00, 0, 1'b0, "restart mismatch R7");

    // R9: bytes after the sixth produce no further decision
    for (int k = 0; k < 8; k++) begin
      put_byte(STN[8*(k%6) +: 8], 1'b0);
      check(!decide_valid, "bytes after sixth R9", decide_valid, 0);
    end

    // R2: a broadcast is not judged as multicast even with a full mask
    mcast_mask = '1;
    frame_check(48'hFFFF_FFFF_FFFF, 8'h08, 8'h08, 0, 1'b0, "bcast not mcast R2");
    run_frame(48'hFFFF_FFFF_FFFE, 8'h00, 8'h00, 0, v, acc, early);
    check(v && !acc && !early, "near broadcast unicast R5", acc, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule